// File: doc/BRIEF.md
# NAND Flash Register Bridge

This block connects a 32-bit processor register bus to one raw 8-bit NAND flash device. Software selects the kind of flash cycle by writing a control word. That word carries a chip-enable request, a cycle-type field and one data byte. For command, address and data-write types, each write produces exactly one write-enable pulse with the byte on the flash I/O bus. In read mode, each read of the data port produces one read-enable pulse and returns the byte sampled from the device. Page-level sequences are built by software as chains of these single-byte accesses.

The bus side uses a request/ready handshake. The bridge holds off the requester until the strobe and its recovery time have finished, then raises `bus_ready` for one cycle. The ready/busy line from the device passes through a synchronizer and can be read as a status bit in the control port.

Top module: `nand_bus_bridge`

## Requirements
- R1: After reset, nand_ce_n, nand_we_n and nand_re_n are 1, nand_cle, nand_ale and nand_dq_oe are 0, and bus_ready is 0.
- R2: A bus write to the control port (bus_addr=0) sets nand_ce_n to the inverse of bit 31 of the written word, and the pin holds until the next control write.
- R3: Bits 30:28 of a control write hold the cycle type. Type 0 (command) drives nand_cle=1 and nand_ale=0. Type 1 (address) drives nand_ale=1 and nand_cle=0. Types 2 to 7 drive both low. CLE and ALE are never high together.
- R4: A control write of type 0, 1 or 3 gives exactly one nand_we_n low pulse, PULSE_CLKS cycles wide. During the pulse, bits 23:16 of the word are on nand_dq_out with nand_dq_oe=1. No read-enable pulse is issued.
- R5: CLE and ALE do not change during the cycle in which nand_we_n falls or the cycle in which it rises, nor the cycle after the rise. nand_dq_oe is already 1 when nand_we_n falls.
- R6: A control write of type 2 (read mode) or of types 4 to 7 only updates the mode and chip-enable state. It issues no strobe.
- R7: In read mode, a bus read of the data port (bus_addr=1) gives one nand_re_n low pulse, PULSE_CLKS cycles wide, with nand_dq_oe=0. It returns nand_dq_in, sampled in the last low cycle, in bits 23:16, and all other bits are zero.
- R8: A bus read of the data port outside read mode returns zero and issues no strobe.
- R9: A bus read of the control port returns the synchronized busy state in bit 15 (1 when nand_rb_n is low), and all other bits are zero.
- R10: An access that issues a strobe completes with bus_ready PULSE_CLKS+HOLD_CLKS+2 cycles after it is accepted. Any other access completes after 1 cycle. bus_ready is high for exactly one cycle.
- R11: A bus write to the data port issues no strobe and leaves nand_ce_n, nand_cle and nand_ale unchanged.
- R12: nand_dq_oe is 0 whenever no write-type cycle is in progress, including all of read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control port, 1 = data port |
| bus_wdata | input | 32 | Write word |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read word, valid with bus_ready |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable strobe, active low |
| nand_re_n | output | 1 | Read enable strobe, active low |
| nand_dq_out | output | 8 | Flash I/O output byte |
| nand_dq_oe | output | 1 | Output enable for the flash I/O bus |
| nand_dq_in | input | 8 | Flash I/O input byte |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
Some properties are checked on every cycle. Write and read strobes never overlap. CLE and ALE are never high together and stay steady around each write-enable edge. The I/O driver is on before write-enable falls and off while read-enable is low. Every strobe is exactly PULSE_CLKS wide, and bus_ready is a single-cycle pulse. Other behaviour only the bench scenarios can show. These are: the mode decoding of every cycle type with both chip-enable settings, the byte on the bus for all 256 values, the bytes returned by read-mode fetches, the access latencies, the zero returns, the ignored writes and the busy bit in the status word.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_SETUP,
      S_PULSE,
      S_HOLD,
      S_DONE
   } seq_state_t;

   typedef enum logic [1:0] {
      K_NONE,
      K_WR,
      K_RD
   } acc_kind_t;

   localparam int MODE_W = 3;
   localparam logic [MODE_W-1:0] MD_CMD  = 3'd0;
   localparam logic [MODE_W-1:0] MD_ADR  = 3'd1;
   localparam logic [MODE_W-1:0] MD_READ = 3'd2;
   localparam logic [MODE_W-1:0] MD_DATA = 3'd3;
endpackage

// File: rtl/nbb_sync.sv
module nbb_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("nbb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_in};
   end

   assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/nbb_mode_reg.sv
module nbb_mode_reg
   import nbb_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              req_we,
   input  logic              req_addr,
   input  logic              wr_ce,
   input  logic [MODE_W-1:0] wr_mode,
   input  logic [BYTE_W-1:0] wr_byte,
   output acc_kind_t         kind,
   output logic              ce_req,
   output logic              cle,
   output logic              ale,
   output logic [BYTE_W-1:0] dq_byte
);
   logic              ce_q;
   logic [MODE_W-1:0] mode_q;
   logic [BYTE_W-1:0] byte_q;
   logic              ctrl_wr;
   logic              wr_strobed;

   assign ctrl_wr    = req_we && !req_addr;
   assign wr_strobed = (wr_mode == MD_CMD) || (wr_mode == MD_ADR) || (wr_mode == MD_DATA);

   always_comb begin
      kind = K_NONE;
      if (ctrl_wr && wr_strobed)                         kind = K_WR;
      else if (!req_we && req_addr && mode_q == MD_READ) kind = K_RD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q   <= 1'b0;
         mode_q <= MD_READ;
         byte_q <= '0;
      end else if (acc && ctrl_wr) begin
         ce_q   <= wr_ce;
         mode_q <= wr_mode;
         if (wr_strobed) byte_q <= wr_byte;
      end
   end

   assign ce_req  = ce_q;
   assign cle     = (mode_q == MD_CMD);
   assign ale     = (mode_q == MD_ADR);
   assign dq_byte = byte_q;

   AST_LATCH_ONLY_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && ctrl_wr) |=> ($stable(mode_q) && $stable(ce_q))); // R11
endmodule

// File: rtl/nbb_cycle_seq.sv
module nbb_cycle_seq
   import nbb_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int PULSE_CLKS = 3,
   parameter int HOLD_CLKS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  acc_kind_t         kind,
   input  logic [BYTE_W-1:0] dq_in,
   output logic              idle,
   output logic              done,
   output logic              we_n,
   output logic              re_n,
   output logic              dq_oe,
   output logic              rd_sel,
   output logic [BYTE_W-1:0] rd_byte
);
   localparam int CMAX   = (PULSE_CLKS > HOLD_CLKS) ? PULSE_CLKS : HOLD_CLKS;
   localparam int CNT_W  = $clog2(CMAX + 1);
   localparam int RUN_W  = $clog2(PULSE_CLKS + 1) + 1;
   localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PULSE_CLKS - 1);
   localparam logic [CNT_W-1:0] H_LAST = CNT_W'(HOLD_CLKS - 1);

   generate
      if (PULSE_CLKS < 1) begin : g_bad_pulse
         $error("nbb_cycle_seq: PULSE_CLKS must be at least 1");
      end
      if (HOLD_CLKS < 1) begin : g_bad_hold
         $error("nbb_cycle_seq: HOLD_CLKS must be at least 1");
      end
   endgenerate

   seq_state_t        state_q;
   acc_kind_t         op_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         op_q    <= K_NONE;
         cnt_q   <= '0;
         rd_q    <= '0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (acc) begin
                  cnt_q <= '0;
                  op_q  <= kind;
                  state_q <= (kind == K_NONE) ? S_DONE : S_SETUP;
               end
            end
            S_SETUP: begin
               cnt_q   <= '0;
               state_q <= S_PULSE;
            end
            S_PULSE: begin
               if (cnt_q == P_LAST) begin
                  cnt_q   <= '0;
                  state_q <= S_HOLD;
                  if (op_q == K_RD) rd_q <= dq_in;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            S_HOLD: begin
               if (cnt_q == H_LAST) state_q <= S_DONE;
               else                 cnt_q   <= cnt_q + 1'b1;
            end
            S_DONE: begin
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign idle    = (state_q == S_IDLE);
   assign done    = (state_q == S_DONE);
   assign we_n    = !(state_q == S_PULSE && op_q == K_WR);
   assign re_n    = !(state_q == S_PULSE && op_q == K_RD);
   assign dq_oe   = (op_q == K_WR) &&
                    (state_q == S_SETUP || state_q == S_PULSE || state_q == S_HOLD);
   assign rd_sel  = (op_q == K_RD);
   assign rd_byte = rd_q;

   // strobe width monitor
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_q <= '0;
      else if (!we_n || !re_n) run_q <= run_q + 1'b1;
      else                     run_q <= '0;
   end

   AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n)); // R4
   AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (run_q == RUN_W'(PULSE_CLKS))); // R4
   AST_RE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(re_n) |-> (run_q == RUN_W'(PULSE_CLKS))); // R7
   AST_OE_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> (dq_oe && $past(dq_oe))); // R5
   AST_NO_OE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !re_n |-> !dq_oe); // R12
   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
   import nbb_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int BYTE_W      = 8,
   parameter int PULSE_CLKS  = 3,
   parameter int HOLD_CLKS   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              bus_ready,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              nand_ce_n,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic [BYTE_W-1:0] nand_dq_out,
   output logic              nand_dq_oe,
   input  logic [BYTE_W-1:0] nand_dq_in,
   input  logic              nand_rb_n
);
   localparam int CE_BIT    = DATA_W - 1;
   localparam int MODE_LSB  = CE_BIT - MODE_W;
   localparam int BYTE_LSB  = 16;
   localparam int BUSY_BIT  = 15;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("nand_bus_bridge: field layout assumes a 32-bit bus");
      end
      if (BYTE_W != 8) begin : g_bad_byte
         $error("nand_bus_bridge: flash I/O must be 8 bits");
      end
   endgenerate

   logic      acc;
   logic      seq_idle;
   logic      rd_sel;
   logic      ce_req;
   logic      rb_sync;
   acc_kind_t kind;
   logic [BYTE_W-1:0] rd_byte;
   logic [DATA_W-1:0] rimm_q;
   logic              unused_wbits;

   assign unused_wbits = ^{bus_wdata[MODE_LSB-1:BYTE_LSB+BYTE_W], bus_wdata[BYTE_LSB-1:0]};
   assign acc = bus_req && seq_idle;

   nbb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rb_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (nand_rb_n),
      .d_out (rb_sync)
   );

   nbb_mode_reg #(.BYTE_W(BYTE_W)) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc),
      .req_we   (bus_we),
      .req_addr (bus_addr),
      .wr_ce    (bus_wdata[CE_BIT]),
      .wr_mode  (bus_wdata[CE_BIT-1:MODE_LSB]),
      .wr_byte  (bus_wdata[BYTE_LSB+BYTE_W-1:BYTE_LSB]),
      .kind     (kind),
      .ce_req   (ce_req),
      .cle      (nand_cle),
      .ale      (nand_ale),
      .dq_byte  (nand_dq_out)
   );

   nbb_cycle_seq #(
      .BYTE_W     (BYTE_W),
      .PULSE_CLKS (PULSE_CLKS),
      .HOLD_CLKS  (HOLD_CLKS)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (acc),
      .kind    (kind),
      .dq_in   (nand_dq_in),
      .idle    (seq_idle),
      .done    (bus_ready),
      .we_n    (nand_we_n),
      .re_n    (nand_re_n),
      .dq_oe   (nand_dq_oe),
      .rd_sel  (rd_sel),
      .rd_byte (rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rimm_q <= '0;
      end else if (acc) begin
         rimm_q <= '0;
         if (!bus_we && !bus_addr) rimm_q[BUSY_BIT] <= !rb_sync;
      end
   end

   always_comb begin
      bus_rdata = rimm_q;
      if (rd_sel) begin
         bus_rdata = '0;
         bus_rdata[BYTE_LSB +: BYTE_W] = rd_byte;
      end
   end

   assign nand_ce_n = !ce_req;

   AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale)); // R3
   AST_LATCH_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nand_we_n) |-> ($stable(nand_cle) && $stable(nand_ale))); // R5
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_we_n) |=> ($stable(nand_cle) && $stable(nand_ale))); // R5
   AST_DQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_out)); // R4
endmodule

// File: tb/sim_nand_bus_bridge.sv
module sim_nand_bus_bridge;
   localparam int CLK_PERIOD = 10;
   localparam int PULSE      = 3;
   localparam int HOLD       = 2;
   localparam int LAT_STROBE = PULSE + HOLD + 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic        bus_addr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_ready;
   logic [31:0] bus_rdata;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]  nand_dq_out;
   logic [7:0]  nand_dq_in = '0;
   logic        nand_rb_n = 1'b1;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_bus_bridge #(.PULSE_CLKS(PULSE), .HOLD_CLKS(HOLD)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
      .bus_rdata(bus_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
      .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
      .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
      .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // results of the last access
   int          r_lat, r_we_low, r_re_low, r_we_pulses, r_re_pulses, r_oe_on_re;
   logic [7:0]  r_dq;
   logic        r_oe_at_we;
   logic [31:0] r_rdata;

   task automatic access(input logic we, input logic addr, input logic [31:0] wd,
                         input logic [7:0] din);
      logic prev_we, prev_re;
      prev_we = 1'b1; prev_re = 1'b1;
      r_lat = 0; r_we_low = 0; r_re_low = 0; r_we_pulses = 0; r_re_pulses = 0;
      r_oe_on_re = 0; r_dq = 'x; r_oe_at_we = 1'b0;
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd; nand_dq_in = din;
      forever begin
         @(negedge clk);
         r_lat++;
         if (!nand_we_n) begin
            r_we_low++;
            if (prev_we) r_we_pulses++;
            r_dq = nand_dq_out;
            r_oe_at_we = nand_dq_oe;
         end
         if (!nand_re_n) begin
            r_re_low++;
            if (prev_re) r_re_pulses++;
            if (nand_dq_oe) r_oe_on_re++;
         end
         prev_we = nand_we_n; prev_re = nand_re_n;
         if (bus_ready) begin
            r_rdata = bus_rdata;
            break;
         end
         if (r_lat > 100) begin
            chk("R10 handshake timeout", 32'(r_lat), 32'(LAT_STROBE));
            break;
         end
      end
      bus_req = 1'b0;
      @(negedge clk);
      chk("R10 ready one cycle", 32'(bus_ready), 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=expired expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] b;
      logic [2:0] m;
      bit strobed;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ce_n", 32'(nand_ce_n), 32'd1);
      chk("R1 we_n", 32'(nand_we_n), 32'd1);
      chk("R1 re_n", 32'(nand_re_n), 32'd1);
      chk("R1 cle/ale/oe", {29'd0, nand_cle, nand_ale, nand_dq_oe}, 32'd0);
      chk("R1 ready", 32'(bus_ready), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // sweep all modes and both chip-enable settings
      for (int md = 0; md < 8; md++) begin
         for (int ce = 0; ce < 2; ce++) begin
            m = 3'(md);
            b = 8'(md * 37 + ce * 91 + 5);
            strobed = (md == 0) || (md == 1) || (md == 3);
            access(1'b1, 1'b0, {1'(ce), m, 4'h0, b, 16'h0}, 8'h00);
            chk("R2 ce_n", 32'(nand_ce_n), 32'(ce == 0));
            chk("R3 cle", 32'(nand_cle), 32'(md == 0));
            chk("R3 ale", 32'(nand_ale), 32'(md == 1));
            chk("R10 latency", 32'(r_lat), strobed ? 32'(LAT_STROBE) : 32'd1);
            chk("R12 oe idle", 32'(nand_dq_oe), 32'd0);
            chk("R4 re pulses", 32'(r_re_pulses), 32'd0);
            if (strobed) begin
               chk("R4 we pulses", 32'(r_we_pulses), 32'd1);
               chk("R4 we width", 32'(r_we_low), 32'(PULSE));
               chk("R4 dq byte", 32'(r_dq), 32'(b));
               chk("R5 oe at we", 32'(r_oe_at_we), 32'd1);
            end else begin
               chk("R6 no we", 32'(r_we_pulses), 32'd0);
            end
         end
      end

      // R4 every byte value in data-write mode
      for (int v = 0; v < 256; v++) begin
         access(1'b1, 1'b0, {1'b1, 3'd3, 4'h0, 8'(v), 16'hA5A5}, 8'h00);
         chk("R4 byte sweep", 32'(r_dq), 32'(v));
      end

      // R11 data-port write ignored (currently mode 3, ce on)
      access(1'b1, 1'b1, {1'b0, 3'd0, 4'h0, 8'h3C, 16'h0}, 8'h00);
      chk("R11 no strobe", 32'(r_we_pulses + r_re_pulses), 32'd0);
      chk("R11 ce_n kept", 32'(nand_ce_n), 32'd0);
      chk("R11 cle/ale kept", {30'd0, nand_cle, nand_ale}, 32'd0);

      // R8 data read outside read mode
      access(1'b0, 1'b1, 32'h0, 8'h77);
      chk("R8 zero", r_rdata, 32'h0);
      chk("R8 no strobe", 32'(r_re_pulses + r_we_pulses), 32'd0);
      chk("R8 latency", 32'(r_lat), 32'd1);

      // R6 enter read mode, then R7 fetch every byte value
      access(1'b1, 1'b0, {1'b1, 3'd2, 4'h0, 8'hEE, 16'h0}, 8'h00);
      chk("R6 read mode no strobe", 32'(r_we_pulses + r_re_pulses), 32'd0);
      for (int v = 0; v < 256; v++) begin
         access(1'b0, 1'b1, 32'h0, 8'(v ^ 8'h5A));
         chk("R7 data", r_rdata, {8'h00, 8'(v ^ 8'h5A), 16'h0000});
         chk("R7 re width", 32'(r_re_low), 32'(PULSE));
         chk("R7 no we, oe off", 32'(r_we_pulses + r_oe_on_re), 32'd0);
         if (v == 0) chk("R10 read latency", 32'(r_lat), 32'(LAT_STROBE));
      end

      // R9 busy bit
      nand_rb_n = 1'b1;
      repeat (4) @(negedge clk);
      access(1'b0, 1'b0, 32'h0, 8'h00);
      chk("R9 ready status", r_rdata, 32'h0);
      nand_rb_n = 1'b0;
      repeat (4) @(negedge clk);
      access(1'b0, 1'b0, 32'h0, 8'h00);
      chk("R9 busy status", r_rdata, 32'h0000_8000);
      chk("R9 no strobe", 32'(r_we_pulses + r_re_pulses), 32'd0);
      nand_rb_n = 1'b1;

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule